// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of address-segment descriptors. Each slot pairs a tag word with a descriptor word. The tag word holds an effective segment number and a valid flag. The descriptor word holds a segment-size code, protection keys, a no-execute flag and a large-page flag. A combinational lookup port compares an effective address against every slot. It returns whether any slot hit, the index of the hit, and both words of that slot. The size code of each slot decides whether it covers a 256 MB segment or a 1 TB segment.

A command port changes or reads the table. It can store a slot, read back either word of a slot, invalidate the slot that maps a given address, or invalidate every slot except slot 0. Commands that break the legality rules are refused, and a one-cycle illegal pulse reports the refusal. Any command that actually clears a valid flag produces a one-cycle request to flush all cached translations. Page-table walking and the flush itself are left to other blocks.

Top module: `slb_array`

## Requirements
- R1: Tag word layout: the valid flag is bit 27 and the segment number is bits 63:28. The size code is descriptor bits 63:62, with 00 for 256 MB and 01 for 1 TB. A lookup hits a slot in two cases. The first is a tag word equal to {address[63:28], valid=1, zeros} together with size code 00. The second is a tag word equal to {address[63:40], zeros, valid=1, zeros} together with size code 01. On a hit, lkEsid and lkVsid show that slot's words. On a miss, lkHit, lkSlot, lkEsid and lkVsid are all zero.
- R2: When several slots hit, the slot with the lowest index is reported.
- R3: cmdOp=1 (store) writes slot cmdRb[log2(N)-1:0]. The tag word keeps only cmdRb bits 63:27, and all lower bits are cleared. The descriptor word takes cmdRs unchanged. Both are visible from the cycle after the command.
- R4: A store is refused when any cmdRb bit in [11:log2(N)] is set. A refused store leaves the table unchanged, and cmdIllegal pulses in the cycle after the command.
- R5: A store is refused, with an illegal pulse, when the size code cmdRs[63:62] is 10 or 11.
- R6: A store with size code 01 is refused, with an illegal pulse, while en1T is low. A store with code 00 is accepted regardless of en1T.
- R7: cmdOp=2 reads the tag word and cmdOp=3 reads the descriptor word of slot cmdRb[log2(N)-1:0]. The result appears on rdData in the cycle after the command. When any bit in cmdRb[11:log2(N)] is set, the read raises cmdIllegal and rdData becomes zero.
- R8: cmdOp=4 looks up cmdRb as an address. On a hit it clears the valid flag of the hit slot and pulses flushReq. On a miss it changes nothing and raises no pulse.
- R9: cmdOp=5 clears the valid flag of every slot except slot 0. It pulses flushReq only when at least one of those flags was set.
- R10: Reset clears every word of every slot to zero, and holds cmdIllegal, flushReq and rdData low.
- R11: cmdIllegal and flushReq are pulses lasting one cycle per command. Idle (0) and unused op codes (6, 7) raise neither pulse and leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en1T | input | 1 | Allows stores of 1 TB segments |
| lkAddr | input | 64 | Effective address for lookup |
| lkHit | output | 1 | Some slot maps lkAddr |
| lkSlot | output | log2(N) | Index of the hit slot |
| lkEsid | output | 64 | Tag word of the hit slot |
| lkVsid | output | 64 | Descriptor word of the hit slot |
| cmdOp | input | 3 | Command: 0 idle, 1 store, 2 read tag, 3 read descriptor, 4 invalidate by address, 5 invalidate all |
| cmdRb | input | 64 | Slot/tag operand, or the address for invalidate |
| cmdRs | input | 64 | Descriptor operand for store |
| rdData | output | 64 | Read result, registered |
| cmdIllegal | output | 1 | Refused command pulse |
| flushReq | output | 1 | Translation flush request pulse |

## Verification
The bench uses an eight-slot table and sweeps every single reserved slot bit from 3 to 11, on both stores and reads. A design that decoded only the low index bits would wrap onto a real slot and corrupt it. It stores 1 TB entries and probes them with addresses whose bits 39:28 differ from the stored tag. A design that ignored the size code would miss these, or would let 256 MB entries match too loosely. It plants a duplicate tag at a higher slot to expose a priority encoder that picks the last match. It also runs invalidate-all twice: the second run has only slot 0 valid and must stay silent. A design that cleared slot 0, or that flushed unconditionally, would show up there.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int VALID_BIT = 27;
  localparam logic [63:0] MASK_256M = 64'hFFFF_FFFF_F000_0000;
  localparam logic [63:0] MASK_1T   = 64'hFFFF_FF00_0000_0000;
  localparam logic [63:0] VALID_W   = 64'h0000_0000_0800_0000;
  localparam logic [63:0] TAG_KEEP  = MASK_256M | VALID_W;
  localparam logic [1:0]  SZ_256M   = 2'b00;
  localparam logic [1:0]  SZ_1T     = 2'b01;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_STORE   = 3'd1,
    OP_RD_TAG  = 3'd2,
    OP_RD_DESC = 3'd3,
    OP_INV_ONE = 3'd4,
    OP_INV_ALL = 3'd5
  } cmd_e;

  typedef struct packed {
    logic wr;
    logic clrOne;
    logic clrAll;
  } slb_strobe_t;
endpackage

// File: rtl/slb_match.sv
module slb_match import slb_pkg::*; #(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [63:0]      addr,
  input  logic [63:0]      tagArr [NUM_ENTRIES],
  input  logic [1:0]       sizeArr [NUM_ENTRIES],
  output logic             hit,
  output logic [IDX_W-1:0] slot
);
  logic [63:0] tag256;
  logic [63:0] tag1T;
  logic [NUM_ENTRIES-1:0] matchVec;

  assign tag256 = (addr & MASK_256M) | VALID_W;
  assign tag1T  = (addr & MASK_1T) | VALID_W;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = ((tagArr[g] == tag256) && (sizeArr[g] == SZ_256M)) ||
                         ((tagArr[g] == tag1T) && (sizeArr[g] == SZ_1T));
  end

  // lowest index wins: scan downward, last assignment is the lowest match
  always_comb begin
    hit  = 1'b0;
    slot = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hit  = 1'b1;
        slot = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/slb_datapath.sv
module slb_datapath import slb_pkg::*; #(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  slb_strobe_t       stb,
  input  logic [63:0]       opRb,
  input  logic [63:0]       opRs,
  input  logic [63:0]       lkAddr,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkSlot,
  output logic [63:0]       lkEsid,
  output logic [63:0]       lkVsid,
  output logic              invHit,
  output logic              upperValid,
  output logic [63:0]       rdEsid,
  output logic [63:0]       rdVsid
);
  logic [63:0] tagQ  [NUM_ENTRIES];
  logic [63:0] descQ [NUM_ENTRIES];
  logic [1:0]  sizeArr [NUM_ENTRIES];
  logic [IDX_W-1:0] invSlot;
  logic [IDX_W-1:0] opIdx;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_size
    assign sizeArr[g] = descQ[g][63:62];
  end

  assign opIdx = opRb[IDX_W-1:0];

  slb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lkMatch (
    .addr(lkAddr), .tagArr(tagQ), .sizeArr(sizeArr), .hit(lkHit), .slot(lkSlot)
  );

  slb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_invMatch (
    .addr(opRb), .tagArr(tagQ), .sizeArr(sizeArr), .hit(invHit), .slot(invSlot)
  );

  assign lkEsid = lkHit ? tagQ[lkSlot]  : '0;
  assign lkVsid = lkHit ? descQ[lkSlot] : '0;
  assign rdEsid = tagQ[opIdx];
  assign rdVsid = descQ[opIdx];

  always_comb begin
    upperValid = 1'b0;
    for (int i = 1; i < NUM_ENTRIES; i++) upperValid = upperValid | tagQ[i][VALID_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagQ[i]  <= '0;
        descQ[i] <= '0;
      end
    end else begin
      if (stb.wr) begin
        tagQ[opIdx]  <= opRb & TAG_KEEP;
        descQ[opIdx] <= opRs;
      end
      if (stb.clrOne) tagQ[invSlot][VALID_BIT] <= 1'b0;
      if (stb.clrAll) begin
        for (int i = 1; i < NUM_ENTRIES; i++) tagQ[i][VALID_BIT] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slb_ctrl.sv
module slb_ctrl import slb_pkg::*; #(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmdOp,
  input  logic [11:IDX_W]   slotHigh,
  input  logic [1:0]        storeSize,
  input  logic              en1T,
  input  logic              invHit,
  input  logic              upperValid,
  input  logic [63:0]       rdEsid,
  input  logic [63:0]       rdVsid,
  output slb_strobe_t       stb,
  output logic [63:0]       rdData,
  output logic              cmdIllegal,
  output logic              flushReq
);
  cmd_e op;
  logic slotBad;
  logic sizeBad;
  logic illNext;
  logic flushNext;

  assign op      = cmd_e'(cmdOp);
  assign slotBad = |slotHigh;
  assign sizeBad = storeSize[1] || ((storeSize == SZ_1T) && !en1T);

  always_comb begin
    stb       = '0;
    illNext   = 1'b0;
    flushNext = 1'b0;
    case (op)
      OP_STORE: begin
        illNext = slotBad || sizeBad;
        stb.wr  = !illNext;
      end
      OP_RD_TAG, OP_RD_DESC: illNext = slotBad;
      OP_INV_ONE: begin
        stb.clrOne = invHit;
        flushNext  = invHit;
      end
      OP_INV_ALL: begin
        stb.clrAll = 1'b1;
        flushNext  = upperValid;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData     <= '0;
      cmdIllegal <= 1'b0;
      flushReq   <= 1'b0;
    end else begin
      cmdIllegal <= illNext;
      flushReq   <= flushNext;
      if (op == OP_RD_TAG)  rdData <= slotBad ? '0 : rdEsid;
      if (op == OP_RD_DESC) rdData <= slotBad ? '0 : rdVsid;
    end
  end
endmodule

// File: rtl/slb_array.sv
module slb_array import slb_pkg::*; #(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en1T,
  input  logic [63:0]       lkAddr,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkSlot,
  output logic [63:0]       lkEsid,
  output logic [63:0]       lkVsid,
  input  logic [2:0]        cmdOp,
  input  logic [63:0]       cmdRb,
  input  logic [63:0]       cmdRs,
  output logic [63:0]       rdData,
  output logic              cmdIllegal,
  output logic              flushReq
);
  slb_strobe_t stb;
  logic invHit;
  logic upperValid;
  logic [63:0] rdEsid;
  logic [63:0] rdVsid;

  slb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rst(rst), .cmdOp(cmdOp), .slotHigh(cmdRb[11:IDX_W]),
    .storeSize(cmdRs[63:62]), .en1T(en1T), .invHit(invHit),
    .upperValid(upperValid), .rdEsid(rdEsid), .rdVsid(rdVsid), .stb(stb),
    .rdData(rdData), .cmdIllegal(cmdIllegal), .flushReq(flushReq)
  );

  slb_datapath #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .opRb(cmdRb), .opRs(cmdRs),
    .lkAddr(lkAddr), .lkHit(lkHit), .lkSlot(lkSlot), .lkEsid(lkEsid),
    .lkVsid(lkVsid), .invHit(invHit), .upperValid(upperValid),
    .rdEsid(rdEsid), .rdVsid(rdVsid)
  );
endmodule

// File: rtl/slb_checker.sv
module slb_checker (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  cmdOp,
  input logic        lkHit,
  input logic [63:0] lkEsid,
  input logic [63:0] lkVsid,
  input logic        cmdIllegal,
  input logic        flushReq
);
  AST_HIT_VALID: assert property (@(posedge clk) disable iff (rst)
    lkHit |-> lkEsid[27]); // R1

  AST_HIT_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    lkHit |-> !lkVsid[63]); // R5

  AST_ILLEGAL_SOURCE: assert property (@(posedge clk) disable iff (rst)
    cmdIllegal |-> ($past(cmdOp) inside {3'd1, 3'd2, 3'd3})); // R4

  AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (rst)
    flushReq |-> ($past(cmdOp) inside {3'd4, 3'd5})); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(cmdOp) inside {3'd0, 3'd6, 3'd7}) |-> (!cmdIllegal && !flushReq)); // R11

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lkHit |-> (lkEsid == 64'd0 && lkVsid == 64'd0)); // R1
endmodule

bind slb_array slb_checker u_chk (.*);

// File: tb/sim_slb_array.sv
`timescale 1ns/1ps
module sim_slb_array;
  localparam int NB = 8;
  localparam logic [63:0] M256 = 64'hFFFF_FFFF_F000_0000;
  localparam logic [63:0] M1T  = 64'hFFFF_FF00_0000_0000;
  localparam logic [63:0] VB   = 64'h0000_0000_0800_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en1T = 1'b1;
  logic [63:0] lkAddr = '0;
  logic lkHit;
  logic [2:0] lkSlot;
  logic [63:0] lkEsid, lkVsid;
  logic [2:0] cmdOp = 3'd0;
  logic [63:0] cmdRb = '0, cmdRs = '0;
  logic [63:0] rdData;
  logic cmdIllegal, flushReq;

  int total = 0;
  int bad = 0;
  logic [63:0] mE [NB];
  logic [63:0] mV [NB];

  always #4 clk = ~clk;

  slb_array #(.NUM_ENTRIES(NB)) u0 (
    .clk(clk), .rst(rst), .en1T(en1T), .lkAddr(lkAddr), .lkHit(lkHit),
    .lkSlot(lkSlot), .lkEsid(lkEsid), .lkVsid(lkVsid), .cmdOp(cmdOp),
    .cmdRb(cmdRb), .cmdRs(cmdRs), .rdData(rdData), .cmdIllegal(cmdIllegal),
    .flushReq(flushReq)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic mLook(input logic [63:0] a, output logic hit, output int slot);
    hit = 1'b0; slot = 0;
    for (int i = NB - 1; i >= 0; i--) begin
      if ((mE[i] == ((a & M256) | VB) && mV[i][63:62] == 2'b00) ||
          (mE[i] == ((a & M1T) | VB) && mV[i][63:62] == 2'b01)) begin
        hit = 1'b1; slot = i;
      end
    end
  endtask

  task automatic checkLk(input logic [63:0] a, input string req);
    logic h; int s;
    @(negedge clk); lkAddr = a; #1;
    mLook(a, h, s);
    check(lkHit == h, req, 64'(lkHit), 64'(h));
    check(lkSlot == (h ? 3'(s) : 3'd0), req, 64'(lkSlot), 64'(h ? s : 0));
    check(lkEsid == (h ? mE[s] : 64'd0), req, lkEsid, h ? mE[s] : 64'd0);
    check(lkVsid == (h ? mV[s] : 64'd0), req, lkVsid, h ? mV[s] : 64'd0);
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [63:0] rb, input logic [63:0] rs, input string req);
    logic slotBad, expIll, expFl, h;
    logic [63:0] expRd;
    int idx, s;
    slotBad = |rb[11:3]; idx = int'(rb[2:0]);
    expIll = 1'b0; expFl = 1'b0; expRd = '0;
    case (op)
      3'd1: begin
        expIll = slotBad || rs[63] || (rs[63:62] == 2'b01 && !en1T);
        if (!expIll) begin mE[idx] = rb & (M256 | VB); mV[idx] = rs; end
      end
      3'd2: begin expIll = slotBad; expRd = slotBad ? 64'd0 : mE[idx]; end
      3'd3: begin expIll = slotBad; expRd = slotBad ? 64'd0 : mV[idx]; end
      3'd4: begin
        mLook(rb, h, s);
        if (h) begin mE[s][27] = 1'b0; expFl = 1'b1; end
      end
      3'd5: begin
        for (int i = 1; i < NB; i++) begin
          if (mE[i][27]) expFl = 1'b1;
          mE[i][27] = 1'b0;
        end
      end
      default: ;
    endcase
    @(negedge clk); cmdOp = op; cmdRb = rb; cmdRs = rs;
    @(negedge clk); cmdOp = 3'd0;
    check(cmdIllegal == expIll, req, 64'(cmdIllegal), 64'(expIll));
    check(flushReq == expFl, req, 64'(flushReq), 64'(expFl));
    if (op == 3'd2 || op == 3'd3) check(rdData == expRd, req, rdData, expRd);
  endtask

  function automatic logic [63:0] segOf(input int i);
    logic [63:0] b;
    b = 64'hA5C3_0000_0000_0000 | (64'(i) << 40);
    if (i % 2 == 0) b = b | (64'(i * 3 + 1) << 28);
    return b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=%h exp=%h", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin mE[i] = '0; mV[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    check(cmdIllegal == 1'b0 && flushReq == 1'b0 && rdData == 64'd0, "R10", rdData, 64'd0);
    for (int i = 0; i < NB; i++) begin
      doCmd(3'd2, 64'(i), 64'd0, "R10");
      doCmd(3'd3, 64'(i), 64'd0, "R10");
    end
    checkLk(64'd0, "R10");
    checkLk(segOf(2), "R10");

    // R3 stores: even slots 256 MB, odd slots 1 TB; junk below bit 27
    for (int i = 0; i < NB; i++) begin
      logic [63:0] rs;
      rs = {(i % 2 == 1) ? 2'b01 : 2'b00, 62'(64'h0001_2345_6789_0F00 * 64'(i + 1))};
      doCmd(3'd1, segOf(i) | VB | 64'h0000_0000_0055_5000 | 64'(i), rs, "R3");
    end
    for (int i = 0; i < NB; i++) begin
      doCmd(3'd2, 64'(i) | 64'hFFFF_0000_0000_0000, 64'd0, "R7");
      doCmd(3'd3, 64'(i), 64'd0, "R7");
    end

    // R1 lookups
    for (int i = 0; i < NB; i++) begin
      checkLk(segOf(i) | 64'h0ABC_DEF, "R1");
      checkLk(segOf(i) | 64'h0000_005A_5000_0000 | 64'h0123_456, "R1");
      checkLk(segOf(i) ^ 64'h0000_0000_4000_0000, "R1");
    end

    // R2 duplicate tag at higher slot; lowest index must win
    doCmd(3'd1, segOf(2) | VB | 64'd6, 64'd0, "R2");
    checkLk(segOf(2) | 64'h77, "R2");
    check(lkSlot == 3'd2, "R2", 64'(lkSlot), 64'd2);

    // R4 reserved slot bits sweep, store and read
    for (int b = 3; b < 12; b++) begin
      doCmd(3'd1, segOf(1) | VB | (64'd1 << b) | 64'd1, 64'd0, "R4");
      doCmd(3'd2, (64'd1 << b) | 64'd1, 64'd0, "R7");
      doCmd(3'd3, (64'd1 << b), 64'd0, "R7");
    end
    doCmd(3'd2, 64'd1, 64'd0, "R4");
    doCmd(3'd3, 64'd1, 64'd0, "R4");

    // R5 bad size codes
    doCmd(3'd1, segOf(3) | VB | 64'd3, 64'h8000_0000_0000_0001, "R5");
    doCmd(3'd1, segOf(3) | VB | 64'd3, 64'hC000_0000_0000_0001, "R5");
    doCmd(3'd3, 64'd3, 64'd0, "R5");

    // R6 1 TB disabled
    en1T = 1'b0;
    doCmd(3'd1, segOf(5) | VB | 64'd4, 64'h4000_0000_0000_00AA, "R6");
    doCmd(3'd1, segOf(7) | VB | 64'd7, 64'h0000_0000_0000_00BB, "R6");
    doCmd(3'd3, 64'd4, 64'd0, "R6");
    doCmd(3'd3, 64'd7, 64'd0, "R6");
    en1T = 1'b1;

    // R8 invalidate by address
    doCmd(3'd4, segOf(3) | 64'h0000_0012_3000_0000, 64'd0, "R8");
    checkLk(segOf(3), "R8");
    doCmd(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R8");
    doCmd(3'd4, segOf(3), 64'd0, "R8");
    doCmd(3'd2, 64'd3, 64'd0, "R8");

    // R11 idle and unused codes
    doCmd(3'd6, segOf(0), 64'd0, "R11");
    doCmd(3'd7, 64'd0, 64'd0, "R11");
    doCmd(3'd0, 64'd0, 64'd0, "R11");
    checkLk(segOf(0), "R11");

    // R9 invalidate all keeps slot 0
    doCmd(3'd5, 64'd0, 64'd0, "R9");
    checkLk(segOf(0) | 64'h55, "R9");
    check(lkHit == 1'b1, "R9", 64'(lkHit), 64'd1);
    for (int i = 1; i < NB; i++) checkLk(segOf(i), "R9");
    doCmd(3'd5, 64'd0, 64'd0, "R9");
    doCmd(3'd2, 64'd0, 64'd0, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule